// File: doc/BRIEF.md
# Dual-Context Configuration Register Bank

This block keeps two complete copies of a search engine's configuration, a foreground copy and a background copy, and presents one of them as the active configuration. Each copy holds a control word, a segment-control word, an address pointer, a primary mask and two persistent selectors (source and destination). A one-cycle toggle command swaps the roles of the two copies. Filtering work can run from one copy while the other is preloaded for a housekeeping task. A swap costs a single command.

A second mask register exists only once and is shared by both contexts. It can be loaded or shifted by one bit in either direction. The active address pointer can step after each completed memory access, upward or downward, as chosen by a field of the active control word. This supports block transfers. Every context swap emits a one-cycle pulse that clears the match state held elsewhere in the device. Instruction decoding sits outside this block. Each register is written through a plain select/data port, to the active copy or to the standby copy. The write data width must be at least the control, segment, address and selector widths, and the control word must be at least 9 bits wide.

Top module: `ctx_cfg_bank`

## Requirements
- R1: After reset the foreground context (act_ctx = 0) is active, every register in both contexts and the shared mask reads zero, and match_clr is low.
- R2: A write with cfg_standby = 0 updates the active context in the next cycle. A write with cfg_standby = 1 updates only the standby context and leaves every active output unchanged. The selects are 0 control, 1 segment, 2 address, 3 primary mask, 4 source selector, 5 destination selector, 6 shared mask. Select 7 writes nothing.
- R3: A cycle with ctx_toggle high flips act_ctx on the next clock edge, and all per-context outputs then show the other context's contents.
- R4: match_clr is high for exactly the one cycle following each cycle in which ctx_toggle was sampled high, and low otherwise.
- R5: Address mode is control bits [1:0]: 01 increments, 10 decrements, 00 and 11 hold. With acc_done high, the active address steps once, and the step wraps modulo 2^ADDR_W.
- R6: A write to the active address in the same cycle as acc_done loads the written value and does not step.
- R7: The standby context's address never steps, whatever its own address mode.
- R8: The shared mask shifts left with m2_shl (a zero enters bit 0) or right with m2_shr (a zero enters the top bit). With both shift inputs high it holds. A write to the shared mask in the same cycle takes precedence over a shift.
- R9: A context swap leaves the shared mask unchanged.
- R10: Control bit 2 drives match_en, bit 3 drives full_en, bits [6:4] drive part_code and bits [8:7] drive mask_pick, all taken from the active control word.
- R11: Registers narrower than the write data take the low-order bits of cfg_wdata.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select |
| cfg_standby | input | 1 | 1 writes the standby context instead of the active one |
| cfg_wdata | input | DATA_W | Write data |
| ctx_toggle | input | 1 | Swap active and standby contexts |
| acc_done | input | 1 | A memory access completed; step the active address |
| m2_shl | input | 1 | Shift shared mask left by one |
| m2_shr | input | 1 | Shift shared mask right by one |
| act_ctx | output | 1 | Active context, 0 = foreground |
| ctrl_word | output | CTRL_W | Active control word |
| seg_word | output | SEG_W | Active segment-control word |
| addr_ptr | output | ADDR_W | Active address pointer |
| mask1 | output | DATA_W | Active primary mask |
| mask2 | output | DATA_W | Shared second mask |
| src_sel | output | SEL_W | Active persistent source selector |
| dst_sel | output | SEL_W | Active persistent destination selector |
| match_en | output | 1 | Match flag enable from active control |
| full_en | output | 1 | Full flag enable from active control |
| part_code | output | 3 | Storage partition code from active control |
| mask_pick | output | 2 | Mask selection from active control |
| match_clr | output | 1 | One-cycle match-state clear after a swap |

## Verification
The assertions take for granted that rst_n is low across the first clock edge, so that no `$past` value comes from before reset. They also treat ctx_toggle, acc_done and the shift inputs as per-cycle commands and not as level-held modes. The step and shift properties exclude same-cycle writes to the register concerned, because a write overrides a step or shift. The stimulus drives every input on the falling edge and holds each command for exactly one cycle. It keeps cfg_sel within the defined selects. It sweeps addresses through both wrap points, and the shared mask through every bit position, under a reduced 16-bit data and 4-bit address configuration.

// File: rtl/ctx_cfg_pkg.sv
package ctx_cfg_pkg;

    typedef enum logic [2:0] {
        SEL_CTRL  = 3'd0,
        SEL_SEG   = 3'd1,
        SEL_ADDR  = 3'd2,
        SEL_MASK1 = 3'd3,
        SEL_SRC   = 3'd4,
        SEL_DST   = 3'd5,
        SEL_MASK2 = 3'd6,
        SEL_NONE  = 3'd7
    } cfg_sel_e;

    typedef enum logic [1:0] {
        AM_HOLD  = 2'b00,
        AM_INC   = 2'b01,
        AM_DEC   = 2'b10,
        AM_HOLD3 = 2'b11
    } addr_mode_e;

    // control word field positions, decoded by neighbouring logic
    localparam int AM_LSB   = 0;
    localparam int MF_BIT   = 2;
    localparam int FF_BIT   = 3;
    localparam int PART_LSB = 4;
    localparam int MSEL_LSB = 7;

endpackage

// File: rtl/addr_stepper.sv
module addr_stepper
    import ctx_cfg_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [1:0]        mode_i,
    input  logic              step_i,
    output logic [ADDR_W-1:0] addr_o
);

    localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

    always_comb begin
        addr_o = addr_i;
        if (step_i) begin
            case (mode_i)
                AM_INC:  addr_o = addr_i + ONE;
                AM_DEC:  addr_o = addr_i - ONE;
                default: addr_o = addr_i;
            endcase
        end
    end

endmodule

// File: rtl/ctx_set.sv
module ctx_set
    import ctx_cfg_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int ADDR_W = 8,
    parameter int CTRL_W = 16,
    parameter int SEG_W  = 16,
    parameter int SEL_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [2:0]        sel,
    input  logic [DATA_W-1:0] wdata,
    input  logic              step_en,
    output logic [CTRL_W-1:0] ctrl_o,
    output logic [SEG_W-1:0]  seg_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W-1:0] mask1_o,
    output logic [SEL_W-1:0]  src_o,
    output logic [SEL_W-1:0]  dst_o
);

    typedef struct packed {
        logic [CTRL_W-1:0] ctrl;
        logic [SEG_W-1:0]  seg;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] mask1;
        logic [SEL_W-1:0]  src;
        logic [SEL_W-1:0]  dst;
    } set_t;

    set_t              s_d, s_q;
    logic [ADDR_W-1:0] addr_step;

    addr_stepper #(.ADDR_W(ADDR_W)) u_step (
        .addr_i (s_q.addr),
        .mode_i (s_q.ctrl[AM_LSB +: 2]),
        .step_i (step_en),
        .addr_o (addr_step)
    );

    always_comb begin
        s_d      = s_q;
        s_d.addr = addr_step;
        if (we) begin
            case (sel)
                SEL_CTRL:  s_d.ctrl  = wdata[CTRL_W-1:0];
                SEL_SEG:   s_d.seg   = wdata[SEG_W-1:0];
                SEL_ADDR:  s_d.addr  = wdata[ADDR_W-1:0];
                SEL_MASK1: s_d.mask1 = wdata;
                SEL_SRC:   s_d.src   = wdata[SEL_W-1:0];
                SEL_DST:   s_d.dst   = wdata[SEL_W-1:0];
                default:   ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign ctrl_o  = s_q.ctrl;
    assign seg_o   = s_q.seg;
    assign addr_o  = s_q.addr;
    assign mask1_o = s_q.mask1;
    assign src_o   = s_q.src;
    assign dst_o   = s_q.dst;

    // R5: increment mode steps by one with wrap
    assert_addr_inc_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && !(we && sel == SEL_ADDR) && s_q.ctrl[AM_LSB +: 2] == AM_INC)
        |=> (s_q.addr == $past(s_q.addr) + ADDR_W'(1)));

    // R5: decrement mode steps down by one with wrap
    assert_addr_dec_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && !(we && sel == SEL_ADDR) && s_q.ctrl[AM_LSB +: 2] == AM_DEC)
        |=> (s_q.addr == $past(s_q.addr) - ADDR_W'(1)));

    // R6: a direct address write overrides the step
    assert_addr_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (we && sel == SEL_ADDR) |=> (s_q.addr == $past(wdata[ADDR_W-1:0])));

    // R7: a set that is neither written nor stepped keeps its contents
    assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!we && !step_en) |=> $stable(s_q));

endmodule

// File: rtl/mask2_shifter.sv
module mask2_shifter #(
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    input  logic              shl,
    input  logic              shr,
    output logic [DATA_W-1:0] mask_o
);

    logic [DATA_W-1:0] m2_d, m2_q;

    always_comb begin
        m2_d = m2_q;
        if (we)              m2_d = wdata;
        else if (shl && !shr) m2_d = {m2_q[DATA_W-2:0], 1'b0};
        else if (shr && !shl) m2_d = {1'b0, m2_q[DATA_W-1:1]};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) m2_q <= '0;
        else        m2_q <= m2_d;
    end

    assign mask_o = m2_q;

    // R8: left shift brings a zero into bit 0
    assert_shl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (shl && !shr && !we) |=> (m2_q == ($past(m2_q) << 1)));

    // R8: right shift brings a zero into the top bit
    assert_shr_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (shr && !shl && !we) |=> (m2_q == ($past(m2_q) >> 1)));

    // R8: opposing shift requests cancel
    assert_both_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (shr && shl && !we) |=> $stable(m2_q));

endmodule

// File: rtl/ctx_cfg_bank.sv
module ctx_cfg_bank
    import ctx_cfg_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int ADDR_W = 8,
    parameter int CTRL_W = 16,
    parameter int SEG_W  = 16,
    parameter int SEL_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [2:0]        cfg_sel,
    input  logic              cfg_standby,
    input  logic [DATA_W-1:0] cfg_wdata,
    input  logic              ctx_toggle,
    input  logic              acc_done,
    input  logic              m2_shl,
    input  logic              m2_shr,
    output logic              act_ctx,
    output logic [CTRL_W-1:0] ctrl_word,
    output logic [SEG_W-1:0]  seg_word,
    output logic [ADDR_W-1:0] addr_ptr,
    output logic [DATA_W-1:0] mask1,
    output logic [DATA_W-1:0] mask2,
    output logic [SEL_W-1:0]  src_sel,
    output logic [SEL_W-1:0]  dst_sel,
    output logic              match_en,
    output logic              full_en,
    output logic [2:0]        part_code,
    output logic [1:0]        mask_pick,
    output logic              match_clr
);

    localparam int N_CTX = 2;

    typedef struct packed {
        logic act;
        logic clr;
    } top_t;

    top_t top_d, top_q;

    logic [CTRL_W-1:0] ctrl_v  [N_CTX];
    logic [SEG_W-1:0]  seg_v   [N_CTX];
    logic [ADDR_W-1:0] addr_v  [N_CTX];
    logic [DATA_W-1:0] mask1_v [N_CTX];
    logic [SEL_W-1:0]  src_v   [N_CTX];
    logic [SEL_W-1:0]  dst_v   [N_CTX];

    logic wr_target;
    logic set_wr;
    logic m2_wr;

    assign wr_target = top_q.act ^ cfg_standby;
    assign m2_wr     = cfg_we && (cfg_sel == SEL_MASK2);
    assign set_wr    = cfg_we && (cfg_sel != SEL_MASK2) && (cfg_sel != SEL_NONE);

    for (genvar g = 0; g < N_CTX; g++) begin : g_ctx
        logic we_g;
        logic step_g;
        assign we_g   = set_wr && (wr_target == 1'(g));
        assign step_g = acc_done && (top_q.act == 1'(g));

        ctx_set #(
            .DATA_W (DATA_W),
            .ADDR_W (ADDR_W),
            .CTRL_W (CTRL_W),
            .SEG_W  (SEG_W),
            .SEL_W  (SEL_W)
        ) u_set (
            .clk     (clk),
            .rst_n   (rst_n),
            .we      (we_g),
            .sel     (cfg_sel),
            .wdata   (cfg_wdata),
            .step_en (step_g),
            .ctrl_o  (ctrl_v[g]),
            .seg_o   (seg_v[g]),
            .addr_o  (addr_v[g]),
            .mask1_o (mask1_v[g]),
            .src_o   (src_v[g]),
            .dst_o   (dst_v[g])
        );
    end

    mask2_shifter #(.DATA_W(DATA_W)) u_mask2 (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (m2_wr),
        .wdata  (cfg_wdata),
        .shl    (m2_shl),
        .shr    (m2_shr),
        .mask_o (mask2)
    );

    always_comb begin
        top_d     = top_q;
        top_d.act = top_q.act ^ ctx_toggle;
        top_d.clr = ctx_toggle;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) top_q <= '0;
        else        top_q <= top_d;
    end

    assign act_ctx   = top_q.act;
    assign match_clr = top_q.clr;
    assign ctrl_word = ctrl_v[top_q.act];
    assign seg_word  = seg_v[top_q.act];
    assign addr_ptr  = addr_v[top_q.act];
    assign mask1     = mask1_v[top_q.act];
    assign src_sel   = src_v[top_q.act];
    assign dst_sel   = dst_v[top_q.act];

    assign match_en  = ctrl_word[MF_BIT];
    assign full_en   = ctrl_word[FF_BIT];
    assign part_code = ctrl_word[PART_LSB +: 3];
    assign mask_pick = ctrl_word[MSEL_LSB +: 2];

    // R3: a toggle command flips the active context
    assert_toggle_flip_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ctx_toggle |=> (act_ctx != $past(act_ctx)));

    // R3: without a toggle the active context holds
    assert_no_toggle_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !ctx_toggle |=> $stable(act_ctx));

    // R4: the clear pulse follows a toggle
    assert_clr_after_toggle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ctx_toggle |=> match_clr);

    // R4: no clear pulse without a toggle
    assert_clr_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !ctx_toggle |=> !match_clr);

    // R9: a swap with no mask-2 command leaves the shared mask alone
    assert_mask2_swap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ctx_toggle && !m2_shl && !m2_shr && !m2_wr) |=> $stable(mask2));

    // R2: a standby write with no other activity leaves the active view unchanged
    assert_standby_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_standby && cfg_sel != SEL_MASK2 && !ctx_toggle && !acc_done)
        |=> ($stable(ctrl_word) && $stable(seg_word) && $stable(addr_ptr)
             && $stable(mask1) && $stable(src_sel) && $stable(dst_sel)));

endmodule

// File: tb/ctx_cfg_bank_tb.sv
`timescale 1ns/1ps
module ctx_cfg_bank_tb;
    import ctx_cfg_pkg::*;

    localparam int DW = 16;
    localparam int AW = 4;
    localparam int CW = 16;
    localparam int SW = 16;
    localparam int LW = 3;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [2:0]    cfg_sel = '0;
    logic          cfg_standby = 1'b0;
    logic [DW-1:0] cfg_wdata = '0;
    logic          ctx_toggle = 1'b0;
    logic          acc_done = 1'b0;
    logic          m2_shl = 1'b0;
    logic          m2_shr = 1'b0;

    logic          act_ctx;
    logic [CW-1:0] ctrl_word;
    logic [SW-1:0] seg_word;
    logic [AW-1:0] addr_ptr;
    logic [DW-1:0] mask1, mask2;
    logic [LW-1:0] src_sel, dst_sel;
    logic          match_en, full_en;
    logic [2:0]    part_code;
    logic [1:0]    mask_pick;
    logic          match_clr;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    ctx_cfg_bank #(.DATA_W(DW), .ADDR_W(AW), .CTRL_W(CW), .SEG_W(SW), .SEL_W(LW)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_standby(cfg_standby), .cfg_wdata(cfg_wdata), .ctx_toggle(ctx_toggle),
        .acc_done(acc_done), .m2_shl(m2_shl), .m2_shr(m2_shr), .act_ctx(act_ctx),
        .ctrl_word(ctrl_word), .seg_word(seg_word), .addr_ptr(addr_ptr),
        .mask1(mask1), .mask2(mask2), .src_sel(src_sel), .dst_sel(dst_sel),
        .match_en(match_en), .full_en(full_en), .part_code(part_code),
        .mask_pick(mask_pick), .match_clr(match_clr)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] sel, input logic sb, input logic [DW-1:0] d);
        cfg_we = 1'b1; cfg_sel = sel; cfg_standby = sb; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0; cfg_standby = 1'b0;
    endtask

    task automatic toggle();
        ctx_toggle = 1'b1;
        @(negedge clk);
        ctx_toggle = 1'b0;
    endtask

    task automatic access();
        acc_done = 1'b1;
        @(negedge clk);
        acc_done = 1'b0;
    endtask

    task automatic shift(input logic l, input logic r);
        m2_shl = l; m2_shr = r;
        @(negedge clk);
        m2_shl = 1'b0; m2_shr = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [DW-1:0] v;
        int a;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk("R1 act_ctx", act_ctx, 0);
        chk("R1 ctrl", ctrl_word, 0);
        chk("R1 seg", seg_word, 0);
        chk("R1 addr", addr_ptr, 0);
        chk("R1 mask1", mask1, 0);
        chk("R1 mask2", mask2, 0);
        chk("R1 src/dst", {src_sel, dst_sel}, 0);
        chk("R1 match_clr", match_clr, 0);

        // R10: sweep the low nine control bits
        for (int c = 0; c < 512; c++) begin
            wr(SEL_CTRL, 1'b0, DW'(c));
            chk("R10 ctrl_word", ctrl_word, c);
            chk("R10 match_en", match_en, (c >> 2) & 1);
            chk("R10 full_en", full_en, (c >> 3) & 1);
            chk("R10 part_code", part_code, (c >> 4) & 7);
            chk("R10 mask_pick", mask_pick, (c >> 7) & 3);
        end
        wr(SEL_CTRL, 1'b0, '0);

        // R2: active vs standby writes
        wr(SEL_SEG, 1'b0, 16'h1234);
        wr(SEL_MASK1, 1'b0, 16'hA5A5);
        wr(SEL_SRC, 1'b0, 16'h0002);
        wr(SEL_DST, 1'b0, 16'h0003);
        wr(SEL_SEG, 1'b1, 16'hBEEF);
        wr(SEL_MASK1, 1'b1, 16'h5A5A);
        wr(SEL_SRC, 1'b1, 16'h0006);
        wr(SEL_DST, 1'b1, 16'h0001);
        wr(SEL_NONE, 1'b0, 16'hFFFF);
        chk("R2 seg active", seg_word, 16'h1234);
        chk("R2 mask1 active", mask1, 16'hA5A5);
        chk("R2 src active", src_sel, 2);
        chk("R2 dst active", dst_sel, 3);
        chk("R2 select 7 no write", ctrl_word, 0);

        // R3, R4: swap to background
        wr(SEL_MASK2, 1'b0, 16'h0F0F);
        ctx_toggle = 1'b1;
        @(negedge clk);
        ctx_toggle = 1'b0;
        chk("R3 act_ctx", act_ctx, 1);
        chk("R4 match_clr high", match_clr, 1);
        chk("R3 seg", seg_word, 16'hBEEF);
        chk("R3 mask1", mask1, 16'h5A5A);
        chk("R3 src", src_sel, 6);
        chk("R3 dst", dst_sel, 1);
        chk("R9 mask2 after swap", mask2, 16'h0F0F);
        @(negedge clk);
        chk("R4 match_clr low", match_clr, 0);
        chk("R3 holds", act_ctx, 1);
        toggle();
        chk("R3 back to fg", act_ctx, 0);
        chk("R3 seg fg", seg_word, 16'h1234);
        chk("R9 mask2 after swap back", mask2, 16'h0F0F);

        // R5: increment across the wrap
        wr(SEL_CTRL, 1'b0, 16'h0001);
        wr(SEL_ADDR, 1'b0, 16'd13);
        a = 13;
        for (int k = 0; k < DEPTH + 4; k++) begin
            access();
            a = (a + 1) % DEPTH;
            chk("R5 inc", addr_ptr, a);
        end
        // R5: decrement across the wrap
        wr(SEL_CTRL, 1'b0, 16'h0002);
        wr(SEL_ADDR, 1'b0, 16'd2);
        a = 2;
        for (int k = 0; k < DEPTH + 4; k++) begin
            access();
            a = (a + DEPTH - 1) % DEPTH;
            chk("R5 dec", addr_ptr, a);
        end
        // R5: hold modes
        for (int m = 0; m < 4; m += 3) begin
            wr(SEL_CTRL, 1'b0, DW'(m));
            wr(SEL_ADDR, 1'b0, 16'd9);
            access();
            access();
            chk("R5 hold", addr_ptr, 9);
        end

        // R6: write beats step
        wr(SEL_CTRL, 1'b0, 16'h0001);
        cfg_we = 1'b1; cfg_sel = SEL_ADDR; cfg_wdata = 16'd4; acc_done = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0; acc_done = 1'b0;
        chk("R6 write wins", addr_ptr, 4);

        // R7: standby address never steps
        wr(SEL_CTRL, 1'b0, 16'h0000);
        wr(SEL_CTRL, 1'b1, 16'h0001);
        wr(SEL_ADDR, 1'b1, 16'd5);
        access(); access(); access();
        chk("R7 active held", addr_ptr, 4);
        toggle();
        chk("R7 standby not stepped", addr_ptr, 5);
        access();
        chk("R7 now active steps", addr_ptr, 6);
        toggle();
        chk("R7 fg untouched", addr_ptr, 4);

        // R8: shift sweep over every bit position
        for (int p = 0; p < DW; p++) begin
            v = DW'((1 << p) | (1 << ((p + 5) % DW)));
            wr(SEL_MASK2, 1'b0, v);
            shift(1'b1, 1'b0);
            chk("R8 shl", mask2, (v << 1) & 16'hFFFF);
            wr(SEL_MASK2, 1'b0, v);
            shift(1'b0, 1'b1);
            chk("R8 shr", mask2, v >> 1);
            shift(1'b1, 1'b1);
            chk("R8 both hold", mask2, v >> 1);
        end
        m2_shl = 1'b1; cfg_we = 1'b1; cfg_sel = SEL_MASK2; cfg_wdata = 16'h8001;
        @(negedge clk);
        m2_shl = 1'b0; cfg_we = 1'b0;
        chk("R8 write beats shift", mask2, 16'h8001);

        // R9: shared mask across a swap
        toggle();
        chk("R9 mask2 shared", mask2, 16'h8001);
        toggle();

        // R11: truncation of narrow registers
        wr(SEL_SRC, 1'b0, 16'hFFFD);
        chk("R11 src trunc", src_sel, 5);
        wr(SEL_ADDR, 1'b0, 16'h1237);
        chk("R11 addr trunc", addr_ptr, 7);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule